// File: doc/BRIEF.md
# Configurable Logic Macrocell Storage Element

This block is the storage and output stage of one programmable logic cell. A data bit reaches it from the cell's combinational function, or from the pad when the registered-input option is on. The bit is held in a single storage element, and configuration inputs turn that element into an edge-triggered D flip-flop, a toggle flip-flop, a level-sensitive latch, or a bypassed path that is purely combinational. The clock or enable is taken from one of eight candidate lines, and each can be used true or inverted.

The candidate clock lines, the preset and clear control lines, and the clock enable are all levels. The block samples them on one system clock. A rising edge of the selected line is recognised when the line is high now and was low at the previous system clock. Preset and clear each pick one line from a set of control lines and can be switched off. When active, they force the visible output at once and load the stored value at the next system clock, and clear takes priority over preset. The power-on value is a configuration input that is loaded while reset is held.

Three outputs leave the cell. One goes to the pad. Two are feedback paths toward the interconnect, and each has its own independent selection.

Top module: `mc_reg_cell`

## Requirements
- R1: While rst_n is low, the stored bit takes the value of cfg_init. After release, in D mode (cfg_mode=1) with no edge and no preset or clear, pad_o shows cfg_init.
- R2: The clock level is clk_src_i[cfg_clk_sel] XOR cfg_clk_inv. An edge is a system clock at which this level is 1 and was 0 at the previous system clock. A level that is already high when reset releases is not an edge.
- R3: In D mode (cfg_mode=1), an edge with ce_i=1 stores the data bit, and pad_o shows it from the following system clock. With ce_i=0, or with no edge, the stored bit is held.
- R4: In T mode (cfg_mode=2), an edge with ce_i=1 and data bit 1 inverts the stored bit. A data bit of 0 leaves the stored bit unchanged.
- R5: In latch mode (cfg_mode=3), the storage is transparent while the clock level is 1: pad_o follows the data bit in the same cycle, and the stored bit follows it at each system clock. While the level is 0, the stored bit is held. ce_i has no effect in this mode.
- R6: In bypass mode (cfg_mode=0), pad_o equals sum_in combinationally, and the stored bit changes only through preset or clear.
- R7: Preset is active when cfg_pst_en=1 and ctl_src_i[cfg_pst_sel]=1. Clear is active when cfg_clr_en=1 and ctl_src_i[cfg_clr_sel]=1. While active, they force the register output to 1 or 0 at once and load that value at the next system clock. When both are active, clear wins.
- R8: The data bit is pad_in when cfg_reg_in=1, and sum_in otherwise.
- R9: fb_a_o is sum_in when cfg_fba_sel=0, and the register output when cfg_fba_sel=1.
- R10: fb_b_o is the register output when cfg_fbb_sel=0, and pad_in when cfg_fbb_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sum_in | input | 1 | Combinational function result |
| pad_in | input | 1 | Level seen at the pad |
| clk_src_i | input | N_CLK | Candidate clock/enable levels |
| ctl_src_i | input | N_CTL | Candidate preset/clear levels |
| ce_i | input | 1 | Clock enable for D and T modes |
| cfg_mode | input | 2 | 0 bypass, 1 D, 2 T, 3 latch |
| cfg_clk_sel | input | CLK_W | Index of the clock candidate |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_pst_en | input | 1 | Enable the preset path |
| cfg_pst_sel | input | CTL_W | Index of the preset line |
| cfg_clr_en | input | 1 | Enable the clear path |
| cfg_clr_sel | input | CTL_W | Index of the clear line |
| cfg_init | input | 1 | Power-on value |
| cfg_reg_in | input | 1 | Take the data bit from the pad |
| cfg_fba_sel | input | 1 | First feedback select |
| cfg_fbb_sel | input | 1 | Second feedback select |
| fb_a_o | output | 1 | First feedback toward the interconnect |
| fb_b_o | output | 1 | Second feedback toward the interconnect |
| pad_o | output | 1 | Output toward the pad |

## Verification
The bench builds the cell with its defaults: eight clock candidates and six control lines. With these, every clock index, both polarities and every preset and clear line can be reached by the random selections. Random steps toggle individual candidate levels, so edges arrive on both selected and unselected lines. The mode and the feedback selections also change in the middle of a run, which brings mode switches with a stale stored bit within reach. Directed steps cover the power-on value for both polarities, the priority of clear over preset, the registered-input load, and an edge on an inverted source.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_DFF    = 2'd1,
        MODE_TFF    = 2'd2,
        MODE_LATCH  = 2'd3
    } mc_mode_e;

    typedef struct packed {
        logic bit_v;     // stored value
        logic clk_prev;  // clock level seen at the previous system clock
    } mc_state_t;
endpackage

// File: rtl/mc_src_pick.sv
module mc_src_pick #(
    parameter int N   = 8,
    parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             inv_i,
    input  logic             en_i,
    output logic             lvl_o
);
    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (SEL_W'(i) == sel_i) picked = src_i[i];
        end
        lvl_o = en_i & (picked ^ inv_i);
    end
endmodule

// File: rtl/mc_fb_mux.sv
module mc_fb_mux (
    input  logic comb_i,
    input  logic reg_i,
    input  logic pad_i,
    input  logic sel_a_i,
    input  logic sel_b_i,
    output logic fb_a_o,
    output logic fb_b_o
);
    always_comb begin
        fb_a_o = sel_a_i ? reg_i : comb_i;
        fb_b_o = sel_b_i ? pad_i : reg_i;
    end
endmodule

// File: rtl/mc_reg_cell.sv
module mc_reg_cell
    import mc_pkg::*;
#(
    parameter int N_CLK = 8,
    parameter int N_CTL = 6,
    localparam int CLK_W = (N_CLK > 1) ? $clog2(N_CLK) : 1,
    localparam int CTL_W = (N_CTL > 1) ? $clog2(N_CTL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_in,
    input  logic             pad_in,
    input  logic [N_CLK-1:0] clk_src_i,
    input  logic [N_CTL-1:0] ctl_src_i,
    input  logic             ce_i,
    input  logic [1:0]       cfg_mode,
    input  logic [CLK_W-1:0] cfg_clk_sel,
    input  logic             cfg_clk_inv,
    input  logic             cfg_pst_en,
    input  logic [CTL_W-1:0] cfg_pst_sel,
    input  logic             cfg_clr_en,
    input  logic [CTL_W-1:0] cfg_clr_sel,
    input  logic             cfg_init,
    input  logic             cfg_reg_in,
    input  logic             cfg_fba_sel,
    input  logic             cfg_fbb_sel,
    output logic             fb_a_o,
    output logic             fb_b_o,
    output logic             pad_o
);
    mc_state_t cur_q, nxt_d;
    mc_mode_e  mode;
    logic      clk_lvl, pst_act, clr_act, edge_w, data_w, reg_view;

    assign mode = mc_mode_e'(cfg_mode);

    mc_src_pick #(.N(N_CLK), .SEL_W(CLK_W)) u_clk_pick (
        .src_i(clk_src_i), .sel_i(cfg_clk_sel), .inv_i(cfg_clk_inv),
        .en_i(1'b1), .lvl_o(clk_lvl));

    mc_src_pick #(.N(N_CTL), .SEL_W(CTL_W)) u_pst_pick (
        .src_i(ctl_src_i), .sel_i(cfg_pst_sel), .inv_i(1'b0),
        .en_i(cfg_pst_en), .lvl_o(pst_act));

    mc_src_pick #(.N(N_CTL), .SEL_W(CTL_W)) u_clr_pick (
        .src_i(ctl_src_i), .sel_i(cfg_clr_sel), .inv_i(1'b0),
        .en_i(cfg_clr_en), .lvl_o(clr_act));

    always_comb begin
        data_w   = cfg_reg_in ? pad_in : sum_in;
        edge_w   = clk_lvl & ~cur_q.clk_prev;
        nxt_d    = cur_q;
        nxt_d.clk_prev = clk_lvl;
        if (clr_act) begin
            nxt_d.bit_v = 1'b0;
        end else if (pst_act) begin
            nxt_d.bit_v = 1'b1;
        end else begin
            case (mode)
                MODE_DFF:   if (edge_w && ce_i) nxt_d.bit_v = data_w;
                MODE_TFF:   if (edge_w && ce_i && data_w) nxt_d.bit_v = ~cur_q.bit_v;
                MODE_LATCH: if (clk_lvl) nxt_d.bit_v = data_w;
                default:    nxt_d.bit_v = cur_q.bit_v;
            endcase
        end
        if (clr_act)                            reg_view = 1'b0;
        else if (pst_act)                       reg_view = 1'b1;
        else if (mode == MODE_LATCH && clk_lvl) reg_view = data_w;
        else                                    reg_view = cur_q.bit_v;
        pad_o = (mode == MODE_BYPASS) ? sum_in : reg_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.bit_v    <= cfg_init;
            cur_q.clk_prev <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    mc_fb_mux u_fb (
        .comb_i(sum_in), .reg_i(reg_view), .pad_i(pad_in),
        .sel_a_i(cfg_fba_sel), .sel_b_i(cfg_fbb_sel),
        .fb_a_o(fb_a_o), .fb_b_o(fb_b_o));

    // R7: clear loads 0 at the next system clock
    p_clear_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> !cur_q.bit_v);
    // R7: preset alone loads 1
    p_preset_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_act && !clr_act) |=> cur_q.bit_v);
    // R3: D mode without an enabled edge holds
    p_dff_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DFF && !(edge_w && ce_i) && !pst_act && !clr_act)
        |=> $stable(cur_q.bit_v));
    // R4: enabled edge with data 1 toggles
    p_tff_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TFF && edge_w && ce_i && data_w && !pst_act && !clr_act)
        |=> (cur_q.bit_v != $past(cur_q.bit_v)));
    // R5: open latch captures the data bit
    p_latch_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LATCH && clk_lvl && !pst_act && !clr_act)
        |=> (cur_q.bit_v == $past(data_w)));
    // R6: bypass leaves the stored bit alone
    p_bypass_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BYPASS && !pst_act && !clr_act) |=> $stable(cur_q.bit_v));
endmodule

// File: tb/mc_reg_cell_tb.sv
module mc_reg_cell_tb;
    localparam int N_CLK = 8;
    localparam int N_CTL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sum_in = 0, pad_in = 0, ce_i = 0;
    logic [N_CLK-1:0] clk_src_i = '0;
    logic [N_CTL-1:0] ctl_src_i = '0;
    logic [1:0] cfg_mode = 2'd1;
    logic [2:0] cfg_clk_sel = 0, cfg_pst_sel = 0, cfg_clr_sel = 0;
    logic cfg_clk_inv = 0, cfg_pst_en = 0, cfg_clr_en = 0, cfg_init = 0;
    logic cfg_reg_in = 0, cfg_fba_sel = 0, cfg_fbb_sel = 0;
    logic fb_a_o, fb_b_o, pad_o;

    int n_chk = 0, n_bad = 0;
    logic m_q, m_prev;
    logic e_view, e_pad;

    mc_reg_cell #(.N_CLK(N_CLK), .N_CTL(N_CTL)) u_dut (
        .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .pad_in(pad_in),
        .clk_src_i(clk_src_i), .ctl_src_i(ctl_src_i), .ce_i(ce_i),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
        .cfg_pst_en(cfg_pst_en), .cfg_pst_sel(cfg_pst_sel),
        .cfg_clr_en(cfg_clr_en), .cfg_clr_sel(cfg_clr_sel),
        .cfg_init(cfg_init), .cfg_reg_in(cfg_reg_in),
        .cfg_fba_sel(cfg_fba_sel), .cfg_fbb_sel(cfg_fbb_sel),
        .fb_a_o(fb_a_o), .fb_b_o(fb_b_o), .pad_o(pad_o));

    always #5 clk = ~clk;

    function automatic logic f_lvl();
        return clk_src_i[cfg_clk_sel] ^ cfg_clk_inv;
    endfunction
    function automatic logic f_pst();
        return cfg_pst_en & ctl_src_i[cfg_pst_sel];
    endfunction
    function automatic logic f_clr();
        return cfg_clr_en & ctl_src_i[cfg_clr_sel];
    endfunction
    function automatic logic f_data();
        return cfg_reg_in ? pad_in : sum_in;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_now();
        if (f_clr())                          e_view = 1'b0;
        else if (f_pst())                     e_view = 1'b1;
        else if (cfg_mode == 2'd3 && f_lvl()) e_view = f_data();
        else                                  e_view = m_q;
        e_pad = (cfg_mode == 2'd0) ? sum_in : e_view;
    endtask

    // called at a negedge with inputs set; checks outputs, advances one clock
    task automatic tick();
        string tg;
        logic nq, lv;
        #1;
        expect_now();
        if (rst_n) begin
            if (f_clr() || f_pst()) tg = "R7";
            else case (cfg_mode)
                2'd0: tg = "R6";
                2'd1: tg = "R3";
                2'd2: tg = "R4";
                default: tg = "R5";
            endcase
            chk(tg, pad_o, e_pad);
            chk("R9", fb_a_o, cfg_fba_sel ? e_view : sum_in);
            chk("R10", fb_b_o, cfg_fbb_sel ? pad_in : e_view);
        end
        lv = f_lvl();
        nq = m_q;
        if (f_clr()) nq = 1'b0;
        else if (f_pst()) nq = 1'b1;
        else case (cfg_mode)
            2'd1: if (lv && !m_prev && ce_i) nq = f_data();
            2'd2: if (lv && !m_prev && ce_i && f_data()) nq = ~m_q;
            2'd3: if (lv) nq = f_data();
            default: ;
        endcase
        @(posedge clk);
        if (rst_n) begin m_q = nq; m_prev = lv; end
        else begin m_q = cfg_init; m_prev = 1'b1; end
        @(negedge clk);
    endtask

    task automatic do_reset(input logic init);
        rst_n = 0; cfg_init = init; m_q = init; m_prev = 1'b1;
        cfg_mode = 2'd1; cfg_pst_en = 0; cfg_clr_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", pad_o, init);
        tick();
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // R1 both power-on polarities
        do_reset(1'b1);
        do_reset(1'b0);

        // R2: inverted source 5, a falling line is a rising edge; R3 capture
        cfg_mode = 2'd1; cfg_clk_sel = 3'd5; cfg_clk_inv = 1; clk_src_i = '1;
        ce_i = 1; sum_in = 1; tick();
        clk_src_i[5] = 0; tick();
        #1; chk("R2", pad_o, 1'b1);
        // R8: registered input from pad
        cfg_reg_in = 1; pad_in = 0; sum_in = 1; clk_src_i[5] = 1; tick();
        clk_src_i[5] = 0; tick();
        #1; chk("R8", pad_o, 1'b0);
        // R7: both active, clear wins; then released it stays 0
        cfg_reg_in = 0; ctl_src_i = 6'b000011; cfg_pst_en = 1; cfg_pst_sel = 0;
        cfg_clr_en = 1; cfg_clr_sel = 1; tick();
        ctl_src_i = 0; #1; chk("R7", pad_o, 1'b0);
        // R5: latch ignores ce, transparent on high level
        cfg_mode = 2'd3; ce_i = 0; clk_src_i[5] = 0; sum_in = 1; #1;
        chk("R5", pad_o, 1'b1); tick();
        // R6: bypass follows sum_in
        cfg_mode = 2'd0; sum_in = 0; #1; chk("R6", pad_o, 1'b0); tick();

        // random mix
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 19) == 0) begin
                cfg_mode    = 2'($urandom_range(0, 3));
                cfg_clk_sel = 3'($urandom_range(0, N_CLK - 1));
                cfg_clk_inv = 1'($urandom_range(0, 1));
                cfg_pst_sel = 3'($urandom_range(0, N_CTL - 1));
                cfg_clr_sel = 3'($urandom_range(0, N_CTL - 1));
                cfg_pst_en  = ($urandom_range(0, 3) == 0);
                cfg_clr_en  = ($urandom_range(0, 3) == 0);
                cfg_reg_in  = 1'($urandom_range(0, 1));
                cfg_fba_sel = 1'($urandom_range(0, 1));
                cfg_fbb_sel = 1'($urandom_range(0, 1));
            end
            for (int b = 0; b < N_CLK; b++)
                if ($urandom_range(0, 2) == 0) clk_src_i[b] = ~clk_src_i[b];
            for (int b = 0; b < N_CTL; b++)
                ctl_src_i[b] = ($urandom_range(0, 7) == 0);
            sum_in = 1'($urandom_range(0, 1));
            pad_in = 1'($urandom_range(0, 1));
            ce_i   = ($urandom_range(0, 3) != 0);
            tick();
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule